// File: doc/BRIEF.md
# Center-Aligned Multichannel PWM Generator

The block drives several pulse-width outputs from a single free-running counter. Every channel produces a pulse that is symmetric about the instant where the low N bits of the counter are zero. N is the resolution, chosen at run time from 8, 9, 10, 11 or 16 bits. The counter is N+1 bits wide and wraps modulo 2^(N+1). Bit N of the counter picks the comparison that is active in each half of the period. While bit N is 1, a channel watches for its falling edge. While bit N is 0, it watches for its rising edge. Because of this, a plain up-counter is enough and no up/down counter is needed.

Each channel has a 16-bit compare value, a polarity bit and a force bit. A compare value whose selected low bits are all ones has no distinct pair of edges. For such a value the channel holds a constant level, and the force bit sets that level. Compare values and the resolution pass through shadow registers, so a change never cuts a period short. The integrator drives the enable input, the resolution code and the per-channel settings, and connects the outputs to pins.

Top module: `cpwm_center_pwm`

## Requirements
- R1: While reset is asserted the counter clears to zero and every channel's internal level is 0, so each output equals its polarity bit.
- R2: The internal level goes to 0 after the clock edge at which counter bit N is 1 and the low N counter bits equal the bitwise inverse of the low N shadow compare bits.
- R3: The internal level goes to 1 after the clock edge at which counter bit N is 0 and the low N shadow compare bits equal the low N counter bits minus one (modulo 2^N).
- R4: For a shadow compare value C below 2^N-1, each period of 2^(N+1) enabled cycles holds exactly two level transitions and exactly 2*(C+1) cycles of internal level 0, centred on the wrap to count zero.
- R5: The resolution code selects N as follows: 0 gives 8, 1 gives 9, 2 gives 10, 3 gives 11, 4 gives 16, and codes 5 to 7 give 8. The counter runs modulo 2^(N+1), so in 16-bit mode a 17th bit selects the edge.
- R6: Each output equals the channel's internal level XOR the channel's polarity bit.
- R7: When the low N shadow compare bits are all ones, the channel's level becomes the channel's force bit on every enabled cycle and never toggles.
- R8: The compare values and the resolution code are captured into the shadow registers only at an enabled clock edge where the counter is at its last count (all N+1 low bits set), or at any edge while the enable is low. A change in mid-period has no effect until the next wrap.
- R9: While the enable is low the counter and every internal level hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one count per enabled cycle |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Counter enable; when low, the counter and levels freeze and the shadows load |
| res_i | input | 3 | Resolution code (0:8, 1:9, 2:10, 3:11, 4:16 bits, others 8) |
| cmp_i | input | 16*NUM_CH | Compare value per channel; channel k occupies bits 16k+15 down to 16k |
| pol_i | input | NUM_CH | Per-channel output inversion |
| force_i | input | NUM_CH | Per-channel level used when the compare value is all ones |
| pwm_o | output | NUM_CH | Per-channel PWM output |

## Verification
At 8-bit resolution, every compare value from 0 to 255 runs for one full period, four channels at a time. Alternating polarity and force masks separate the inversion path from the edge logic. The per-count waveform, the low width, the transition count and the exact counts of the falling and rising edges are checked against an arithmetic model. A wrong operand in the inverse-match or minus-one comparison therefore shows up as a width or position error. Runs at 9, 10 and 11 bits cover a pause in mid-period and a compare change in mid-period. A run of 70000 cycles at 16 bits shows that the counter does not wrap early and that the 17th bit picks the edge. All-ones compare values with each force level confirm the constant-level case.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   localparam int CPWM_CMP_W = 16;
   localparam int CPWM_CNT_W = CPWM_CMP_W + 1;
   localparam int CPWM_RES_W = 3;

   typedef logic [CPWM_CMP_W-1:0] cmp_t;
   typedef logic [CPWM_CNT_W-1:0] cnt_t;
   typedef logic [CPWM_RES_W-1:0] res_t;

   typedef enum logic [CPWM_RES_W-1:0] {
      RES_8  = 3'd0,
      RES_9  = 3'd1,
      RES_10 = 3'd2,
      RES_11 = 3'd3,
      RES_16 = 3'd4
   } res_e;

   // mask of the low N bits for a resolution code
   function automatic cmp_t low_mask(input res_t code);
      cmp_t m;
      case (code)
         RES_9:   m = 16'h01FF;
         RES_10:  m = 16'h03FF;
         RES_11:  m = 16'h07FF;
         RES_16:  m = 16'hFFFF;
         default: m = 16'h00FF;
      endcase
      return m;
   endfunction

   // mask of the N+1 counter bits
   function automatic cnt_t cnt_mask(input res_t code);
      return {low_mask(code), 1'b1};
   endfunction

   // counter bit N, the half-period selector
   function automatic logic dir_bit(input cnt_t c, input res_t code);
      logic b;
      case (code)
         RES_9:   b = c[9];
         RES_10:  b = c[10];
         RES_11:  b = c[11];
         RES_16:  b = c[16];
         default: b = c[8];
      endcase
      return b;
   endfunction

endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
   import cpwm_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  res_t res_i,
   output cnt_t cnt_o,
   output logic last_o
);

   cnt_t mask_w;
   cnt_t cnt_q;
   cnt_t cnt_d;

   assign mask_w = cnt_mask(res_i);

   always_comb begin
      cnt_d = cnt_q;
      if (en_i) begin
         cnt_d = (cnt_q + cnt_t'(1)) & mask_w;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o  = cnt_q;
   assign last_o = ((cnt_q & mask_w) == mask_w);

endmodule

// File: rtl/cpwm_edge_match.sv
module cpwm_edge_match
   import cpwm_pkg::*;
(
   input  cnt_t cnt_i,
   input  res_t res_i,
   input  cmp_t cmp_i,
   output logic fall_o,
   output logic rise_o,
   output logic full_o
);

   cmp_t lmask_w;
   cmp_t cnt_lo_w;
   cmp_t cmp_lo_w;
   cmp_t inv_lo_w;
   cmp_t prev_lo_w;
   logic sel_w;

   assign lmask_w   = low_mask(res_i);
   assign cnt_lo_w  = cnt_i[CPWM_CMP_W-1:0] & lmask_w;
   assign cmp_lo_w  = cmp_i & lmask_w;
   assign inv_lo_w  = (~cmp_i) & lmask_w;
   assign prev_lo_w = (cnt_lo_w - cmp_t'(1)) & lmask_w;
   assign sel_w     = dir_bit(cnt_i, res_i);

   assign fall_o = sel_w && (cnt_lo_w == inv_lo_w);
   assign rise_o = !sel_w && (cmp_lo_w == prev_lo_w);
   assign full_o = (cmp_lo_w == lmask_w);

endmodule

// File: rtl/cpwm_channel.sv
module cpwm_channel
   import cpwm_pkg::*;
#(
   parameter bit REG_POL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic load_i,
   input  cnt_t cnt_i,
   input  res_t res_i,
   input  cmp_t cmp_i,
   input  logic pol_i,
   input  logic force_i,
   output cmp_t cmp_sh_o,
   output logic lvl_o,
   output logic full_o,
   output logic pwm_o
);

   cmp_t cmp_sh_q;
   logic lvl_q;
   logic fall_w;
   logic rise_w;
   logic full_w;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cmp_sh_q <= '0;
      end else if (load_i) begin
         cmp_sh_q <= cmp_i;
      end
   end

   cpwm_edge_match u_match (
      .cnt_i  (cnt_i),
      .res_i  (res_i),
      .cmp_i  (cmp_sh_q),
      .fall_o (fall_w),
      .rise_o (rise_w),
      .full_o (full_w)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         lvl_q <= 1'b0;
      end else if (en_i) begin
         if (full_w) begin
            lvl_q <= force_i;
         end else if (fall_w) begin
            lvl_q <= 1'b0;
         end else if (rise_w) begin
            lvl_q <= 1'b1;
         end
      end
   end

   generate
      if (REG_POL) begin : g_pol_reg
         logic pwm_q;
         always_ff @(posedge clk_i) begin
            if (rst_i) begin
               pwm_q <= 1'b0;
            end else begin
               pwm_q <= lvl_q ^ pol_i;
            end
         end
         assign pwm_o = pwm_q;
      end else begin : g_pol_comb
         assign pwm_o = lvl_q ^ pol_i;
      end
   endgenerate

   assign cmp_sh_o = cmp_sh_q;
   assign lvl_o    = lvl_q;
   assign full_o   = full_w;

endmodule

// File: rtl/cpwm_center_pwm.sv
module cpwm_center_pwm
   import cpwm_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter bit REG_POL = 1'b0
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       en_i,
   input  logic [CPWM_RES_W-1:0]      res_i,
   input  logic [NUM_CH*CPWM_CMP_W-1:0] cmp_i,
   input  logic [NUM_CH-1:0]          pol_i,
   input  logic [NUM_CH-1:0]          force_i,
   output logic [NUM_CH-1:0]          pwm_o
);

   localparam int CMP_BUS_W = NUM_CH * CPWM_CMP_W;

   generate
      if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_nch
         $error("cpwm_center_pwm: NUM_CH must lie in 1..32");
      end
      if (CMP_BUS_W != NUM_CH * 16) begin : g_bad_bus
         $error("cpwm_center_pwm: compare bus width mismatch");
      end
   endgenerate

   res_t res_q;
   cnt_t cnt_w;
   logic last_w;
   logic wrap_w;
   logic load_w;

   logic [CMP_BUS_W-1:0] cmp_sh_w;
   logic [NUM_CH-1:0]    lvl_w;
   logic [NUM_CH-1:0]    full_w;

   assign wrap_w = en_i && last_w;
   assign load_w = wrap_w || !en_i;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_q <= RES_8;
      end else if (load_w) begin
         res_q <= res_i;
      end
   end

   cpwm_counter u_cnt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (en_i),
      .res_i  (res_q),
      .cnt_o  (cnt_w),
      .last_o (last_w)
   );

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         cpwm_channel #(
            .REG_POL (REG_POL)
         ) u_chan (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .en_i     (en_i),
            .load_i   (load_w),
            .cnt_i    (cnt_w),
            .res_i    (res_q),
            .cmp_i    (cmp_i[ch*CPWM_CMP_W +: CPWM_CMP_W]),
            .pol_i    (pol_i[ch]),
            .force_i  (force_i[ch]),
            .cmp_sh_o (cmp_sh_w[ch*CPWM_CMP_W +: CPWM_CMP_W]),
            .lvl_o    (lvl_w[ch]),
            .full_o   (full_w[ch]),
            .pwm_o    (pwm_o[ch])
         );
      end
   endgenerate

endmodule

// File: rtl/cpwm_center_pwm_chk.sv
module cpwm_center_pwm_chk
   import cpwm_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input logic                         clk_i,
   input logic                         rst_i,
   input logic                         en_i,
   input logic [NUM_CH-1:0]            force_i,
   input res_t                         res_q,
   input cnt_t                         cnt_q,
   input logic                         wrap,
   input logic [NUM_CH*CPWM_CMP_W-1:0] cmp_sh,
   input logic [NUM_CH-1:0]            lvl,
   input logic [NUM_CH-1:0]            full
);

   logic sel_w;
   assign sel_w = dir_bit(cnt_q, res_q);

   // R1
   cnt_reset_zero_chk: assert property (@(posedge clk_i)
      rst_i |=> (cnt_q == '0));

   // R1
   lvl_reset_low_chk: assert property (@(posedge clk_i)
      rst_i |=> (lvl == '0));

   // R9
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(cnt_q));

   // R9
   lvl_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> $stable(lvl));

   // R8
   shadow_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(cmp_sh) |-> $past(wrap || !en_i || rst_i));

   // R8
   res_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(res_q) |-> $past(wrap || !en_i || rst_i));

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch_chk
         // R7
         force_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            (en_i && full[ch]) |=> (lvl[ch] == $past(force_i[ch])));

         // R2
         fall_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ($fell(lvl[ch]) && !$past(full[ch])) |-> $past(sel_w));

         // R3
         rise_half_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ($rose(lvl[ch]) && !$past(full[ch])) |-> !$past(sel_w));
      end
   endgenerate

endmodule

bind cpwm_center_pwm cpwm_center_pwm_chk #(
   .NUM_CH (NUM_CH)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .en_i    (en_i),
   .force_i (force_i),
   .res_q   (res_q),
   .cnt_q   (cnt_w),
   .wrap    (wrap_w),
   .cmp_sh  (cmp_sh_w),
   .lvl     (lvl_w),
   .full    (full_w)
);

// File: tb/cpwm_center_pwm_tb_top.sv
module cpwm_center_pwm_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 4;
   localparam int WDOG_CYC   = 190000;

   logic              clk;
   logic              rst;
   logic              en;
   logic [2:0]        res;
   logic [NCH*16-1:0] cmp_bus;
   logic [NCH-1:0]    pol;
   logic [NCH-1:0]    frc;
   logic [NCH-1:0]    pwm;

   logic [15:0] drv_cmp [NCH];
   int          m_cmp [NCH];
   int          m_res_n;
   int          m_cnt;
   logic [2:0]  m_res;
   logic [NCH-1:0] samp [0:4095];

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   cpwm_center_pwm #(.NUM_CH(NCH)) dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .en_i    (en),
      .res_i   (res),
      .cmp_i   (cmp_bus),
      .pol_i   (pol),
      .force_i (frc),
      .pwm_o   (pwm)
   );

   always_comb begin
      for (int c = 0; c < NCH; c++) cmp_bus[c*16 +: 16] = drv_cmp[c];
   end

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int nbits(input logic [2:0] code);
      case (code)
         3'd1: return 9;
         3'd2: return 10;
         3'd3: return 11;
         3'd4: return 16;
         default: return 8;
      endcase
   endfunction

   // expected internal level seen while the counter shows k
   function automatic bit exp_lvl(input int k, input int c, input int n, input bit f);
      int lm, cl, hi, lo, nc;
      lm = (1 << n) - 1;
      cl = c & lm;
      if (cl == lm) return f;
      hi = (k >> n) & 1;
      lo = k & lm;
      nc = (~cl) & lm;
      if (hi == 1) return !(lo > nc);
      return !(lo <= cl + 1);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   // one clock with the bench's own model of counter and shadows
   task automatic step();
      bit load;
      int mask;
      @(posedge clk);
      mask = (1 << (m_res_n + 1)) - 1;
      if (rst) begin
         m_cnt = 0;
         m_res = 3'd0;
         m_res_n = 8;
         for (int c = 0; c < NCH; c++) m_cmp[c] = 0;
      end else begin
         load = 1'b1;
         if (en) begin
            load = ((m_cnt & mask) == mask);
            m_cnt = (m_cnt + 1) & mask;
         end
         if (load) begin
            m_res = res;
            m_res_n = nbits(res);
            for (int c = 0; c < NCH; c++) m_cmp[c] = int'(drv_cmp[c]);
         end
      end
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      en  = 1'b0;
      repeat (3) step();
      rst = 1'b0;
   endtask

   // run one period of enabled cycles; samples land at their count
   task automatic run_period(input bit analyze, input string tag,
                             input int pause_at, input int change_at,
                             input int nxt0, input int nxt1,
                             input int nxt2, input int nxt3);
      int n, per, lm;
      int c_snap [NCH];
      logic [NCH-1:0] hold;
      n   = m_res_n;
      per = 1 << (n + 1);
      lm  = (1 << n) - 1;
      for (int c = 0; c < NCH; c++) c_snap[c] = m_cmp[c] & lm;
      en = 1'b1;
      for (int s = 0; s < per; s++) begin
         step();
         samp[m_cnt] = pwm;
         if (m_cnt == pause_at) begin
            en = 1'b0;
            hold = pwm;
            for (int p = 0; p < 20; p++) begin
               step();
               // R9: frozen outputs while disabled
               check(pwm == hold, "R9", "output held while disabled",
                     int'(pwm), int'(hold));
            end
            check(m_cnt == pause_at, "R9", "model count frozen", m_cnt, pause_at);
            en = 1'b1;
         end
         if (m_cnt == change_at) begin
            drv_cmp[0] = 16'(nxt0);
            drv_cmp[1] = 16'(nxt1);
            drv_cmp[2] = 16'(nxt2);
            drv_cmp[3] = 16'(nxt3);
         end
      end
      if (analyze) begin
         for (int c = 0; c < NCH; c++) begin
            int mism, first_k, lows, trans, cv, nc;
            bit e, a, a2;
            string rq;
            cv = c_snap[c];
            mism = 0; first_k = -1; lows = 0; trans = 0;
            for (int k = 0; k < per; k++) begin
               a  = samp[k][c] ^ pol[c];
               a2 = samp[(k + 1) % per][c] ^ pol[c];
               e  = exp_lvl(k, cv, n, frc[c]);
               if (a != e) begin
                  mism++;
                  if (first_k < 0) first_k = k;
               end
               if (!a) lows++;
               if (a != a2) trans++;
            end
            if (cv == lm)       rq = "R7";
            else if (pol[c])    rq = "R6";
            else                rq = tag;
            check(mism == 0, rq, $sformatf("waveform ch%0d C=%0d mismatches (first at %0d)",
                  c, cv, first_k), mism, 0);
            if (cv == lm) begin
               // R7: no toggling at all
               check(trans == 0, "R7", $sformatf("ch%0d transitions", c), trans, 0);
            end else begin
               // R4: width and edge count
               check(lows == 2 * (cv + 1), "R4",
                     $sformatf("ch%0d C=%0d low cycles", c, cv), lows, 2 * (cv + 1));
               check(trans == 2, "R4", $sformatf("ch%0d transitions", c), trans, 2);
               // R3: rising edge at count C+1, visible from C+2
               a  = samp[cv + 1][c] ^ pol[c];
               a2 = samp[cv + 2][c] ^ pol[c];
               check(!a && a2, "R3", $sformatf("ch%0d C=%0d rise position", c, cv),
                     {a, a2}, 2'b01);
               nc = (~cv) & lm;
               if (nc != lm) begin
                  // R2: falling edge at 2^N + ~C, visible one count later
                  a  = samp[(1 << n) + nc][c] ^ pol[c];
                  a2 = samp[(1 << n) + nc + 1][c] ^ pol[c];
                  check(a && !a2, "R2", $sformatf("ch%0d C=%0d fall position", c, cv),
                        {a, a2}, 2'b10);
               end
            end
         end
      end
   endtask

   task automatic set_cfg(input logic [2:0] r, input int c0, input int c1,
                          input int c2, input int c3,
                          input logic [NCH-1:0] p, input logic [NCH-1:0] f);
      en  = 1'b0;
      res = r;
      drv_cmp[0] = 16'(c0);
      drv_cmp[1] = 16'(c1);
      drv_cmp[2] = 16'(c2);
      drv_cmp[3] = 16'(c3);
      pol = p;
      frc = f;
      step();
   endtask

   initial begin
      rst = 1'b1;
      en  = 1'b0;
      res = 3'd0;
      pol = 4'b0101;
      frc = '0;
      for (int c = 0; c < NCH; c++) drv_cmp[c] = 16'h0;
      m_cnt = 0; m_res = 3'd0; m_res_n = 8;
      for (int c = 0; c < NCH; c++) m_cmp[c] = 0;

      do_reset();
      // R1: outputs equal polarity after reset
      check(pwm == 4'b0101, "R1", "outputs after reset", int'(pwm), 5);
      pol = 4'b0000;
      @(negedge clk);
      check(pwm == 4'b0000, "R1", "non-inverted outputs low after reset", int'(pwm), 0);

      // R5: 16-bit run, counter must reach past 2^16 without wrapping
      begin
         int mism [NCH];
         set_cfg(3'd4, 16'h0000, 16'hF000, 16'h0010, 16'hFFFF, 4'b0000, 4'b1000);
         for (int c = 0; c < NCH; c++) mism[c] = 0;
         en = 1'b1;
         for (int s = 0; s < 70000; s++) begin
            step();
            for (int c = 0; c < NCH; c++)
               if (pwm[c] != exp_lvl(m_cnt, m_cmp[c], 16, frc[c])) mism[c]++;
         end
         for (int c = 0; c < NCH; c++)
            check(mism[c] == 0, "R5", $sformatf("16-bit ch%0d mismatching cycles", c),
                  mism[c], 0);
         check(pwm[1] == 1'b0, "R5", "16-bit ch1 low after 17th-bit fall", int'(pwm[1]), 0);
      end

      do_reset();

      // 8-bit sweep of every compare value, four channels at once
      for (int g = 0; g < 64; g++) begin
         set_cfg(3'd0, 4*g, 4*g + 1, 4*g + 2, 4*g + 3,
                 g[0] ? 4'b1010 : 4'b0000, g[0] ? 4'b1111 : 4'b0000);
         run_period(1'b1, "R2", -1, -1, 0, 0, 0, 0);
      end

      // R5: 9-bit, all-ones compare forced low
      set_cfg(3'd1, 0, 77, 510, 511, 4'b0100, 4'b0000);
      run_period(1'b0, "R5", -1, -1, 0, 0, 0, 0);
      run_period(1'b1, "R5", -1, -1, 0, 0, 0, 0);

      // R5 / R9: 10-bit with a pause in mid-period, forced high inverted
      set_cfg(3'd2, 5, 512, 1000, 1023, 4'b1000, 4'b1000);
      run_period(1'b0, "R5", -1, -1, 0, 0, 0, 0);
      run_period(1'b1, "R5", 300, -1, 0, 0, 0, 0);

      // R8: 11-bit, compare inputs change at count 1000, effect only after wrap
      set_cfg(3'd3, 10, 1500, 2046, 300, 4'b0000, 4'b0000);
      run_period(1'b0, "R8", -1, -1, 0, 0, 0, 0);
      run_period(1'b1, "R8", -1, 1000, 20, 100, 2000, 1024);
      run_period(1'b1, "R8", -1, -1, 0, 0, 0, 0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule